// File: doc/BRIEF.md
# Master Clock Rate Detector

This block works out, after power-up, which of four permitted master clock frequencies is driving it. It uses the 8 kHz frame strobe as a time base. The strobe is synchronous to the master clock. The block counts master clock cycles from one rising edge of the strobe to the next. It sorts each count into a rate class and reports a 2-bit rate code, together with a lock flag, to the clock dividers downstream. The 1.536 MHz and 1.544 MHz clocks give 192 and 193 cycles per frame, and the block treats them as one class. The other classes are 2.048 MHz, 4.096 MHz and 8.192 MHz.

A class is accepted only when it is measured on two frames in a row. When a frame's count fits no class, the lock is dropped, and a new measurement starts from the same strobe edge. The period counter stops at its top value, so a frame strobe that stops arriving shows up as an out-of-range count and never wraps into a false match. All pins are plain control or status signals and carry no data stream, so there is no handshake.

Top module: `mcr_rate_detect`

## Requirements
- R1: While reset is asserted and after it is released, `rate_lock_o` is 0 and `rate_code_o` is 00. Both stay that way until a lock is reached.
- R2: A measured count in 190..195 is class 00. A count in 254..258 is class 01, 510..514 is class 10, and 1022..1026 is class 11. When locked, `rate_code_o` carries the class code.
- R3: `rate_lock_o` is set when two consecutive measurements give the same class. It is visible one clock after the clock edge that samples the rising strobe edge closing the second measurement.
- R4: The first rising strobe edge after reset only starts a measurement. At least three rising edges are therefore needed before a lock can be reached.
- R5: A measurement that fits no class clears `rate_lock_o`. The strobe edge that closed it also starts the next measurement, so two further matching frames restore the lock.
- R6: While locked, a matching measurement of a different class clears the lock. That class becomes the new candidate and locks on the next frame that gives the same class.
- R7: The cycle counter saturates at 2047. A gap of 2047 or more cycles between strobe edges is measured as 2047, which fits no class.
- R8: `rate_code_o` reads 00 whenever `rate_lock_o` is 0.
- R9: Only the rising edge of the strobe counts. A strobe held high for several cycles marks a single frame boundary.
- R10: `rate_lock_o` and `rate_code_o` change only in the cycle after a strobe rising edge that closes a measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock under measurement |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_strobe_i | input | 1 | 8 kHz frame strobe, synchronous to `clk_i` |
| rate_code_o | output | 2 | Detected rate class; 00 while unlocked |
| rate_lock_o | output | 1 | High when the same class has been measured on two consecutive frames |

## Verification
The bench tests each class at both edges of its ±2 window and one count beyond each edge. An off-by-one window would lock on 189 or refuse to lock on 195. It checks that three strobe edges are needed after reset: a design that measures from reset would lock one frame early. It checks that a mismatch or a class change drops the lock and that relocking takes exactly two good frames. It stalls the strobe for more than 2047 cycles: a wrapping counter could then land inside a class and keep a false lock. Wide strobe pulses show up any design that counts the level instead of the rising edge.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  localparam int NUM_RATES = 4;
  localparam int RATE_W    = $clog2(NUM_RATES);

  typedef enum logic [RATE_W-1:0] {
    RATE_1M5   = 2'd0,
    RATE_2M048 = 2'd1,
    RATE_4M096 = 2'd2,
    RATE_8M192 = 2'd3
  } rate_e;

  // Lowest nominal count per frame for a class index.
  function automatic int nom_lo(input int idx);
    return (idx == 0) ? 192 : (256 << (idx - 1));
  endfunction

  // Highest nominal count per frame for a class index.
  function automatic int nom_hi(input int idx);
    return (idx == 0) ? 193 : (256 << (idx - 1));
  endfunction

endpackage

// File: rtl/mcr_period_counter.sv
module mcr_period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  output logic             meas_valid_o,
  output logic [CNT_W-1:0] meas_count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             strobe_d_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise = strobe_i & ~strobe_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_d_q <= 1'b0;
      armed_q    <= 1'b0;
      cnt_q      <= '0;
    end else begin
      strobe_d_q <= strobe_i;
      if (rise) begin
        armed_q <= 1'b1;
        cnt_q   <= CNT_W'(1);
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // A measurement closes on every rising edge except the first one after reset.
  assign meas_valid_o = rise & armed_q;
  assign meas_count_o = cnt_q;

  AST_CNT_HOLDS_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !rise) |=> (cnt_q == CNT_MAX)); // R7

  AST_LEVEL_NOT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && strobe_d_q) |-> !meas_valid_o); // R9

endmodule

// File: rtl/mcr_classifier.sv
module mcr_classifier
  import mcr_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  output logic              hit_any_o,
  output logic [RATE_W-1:0] code_o
);

  logic [NUM_RATES-1:0] hit;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_class
    localparam int LO = nom_lo(g) - TOL;
    localparam int HI = nom_hi(g) + TOL;
    assign hit[g] = (int'(count_i) >= LO) && (int'(count_i) <= HI);
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (hit[i]) code_o = RATE_W'(i);
    end
  end

  assign hit_any_o = |hit;

  AST_ONE_CLASS_AT_MOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit)); // R2

endmodule

// File: rtl/mcr_lock_tracker.sv
module mcr_lock_tracker
  import mcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              meas_valid_i,
  input  logic              hit_any_i,
  input  logic [RATE_W-1:0] code_i,
  output logic              lock_o,
  output logic [RATE_W-1:0] rate_o
);

  logic              lock_q;
  logic              have_prev_q;
  logic [RATE_W-1:0] prev_q;
  logic [RATE_W-1:0] rate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q      <= 1'b0;
      have_prev_q <= 1'b0;
      prev_q      <= '0;
      rate_q      <= '0;
    end else if (meas_valid_i) begin
      if (!hit_any_i) begin
        lock_q      <= 1'b0;
        have_prev_q <= 1'b0;
      end else if (have_prev_q && (prev_q == code_i)) begin
        lock_q <= 1'b1;
        rate_q <= code_i;
      end else begin
        lock_q      <= 1'b0;
        have_prev_q <= 1'b1;
        prev_q      <= code_i;
      end
    end
  end

  assign lock_o = lock_q;
  assign rate_o = lock_q ? rate_q : '0;

  AST_HOLD_BETWEEN_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(meas_valid_i) |-> ($stable(lock_o) && $stable(rate_o))); // R10

  AST_MISS_DROPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_valid_i && !hit_any_i) |=> !lock_o); // R5

  AST_LOCK_AFTER_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(meas_valid_i && hit_any_i)); // R3

endmodule

// File: rtl/mcr_rate_detect.sv
module mcr_rate_detect
  import mcr_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_strobe_i,
  output logic [RATE_W-1:0] rate_code_o,
  output logic              rate_lock_o
);

  logic              meas_valid;
  logic [CNT_W-1:0]  meas_count;
  logic              hit_any;
  logic [RATE_W-1:0] hit_code;

  mcr_period_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strobe_i     (frame_strobe_i),
    .meas_valid_o (meas_valid),
    .meas_count_o (meas_count)
  );

  mcr_classifier #(.CNT_W(CNT_W), .TOL(TOL)) i_classifier (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_i   (meas_count),
    .hit_any_o (hit_any),
    .code_o    (hit_code)
  );

  mcr_lock_tracker i_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .meas_valid_i (meas_valid),
    .hit_any_i    (hit_any),
    .code_i       (hit_code),
    .lock_o       (rate_lock_o),
    .rate_o       (rate_code_o)
  );

  AST_CODE_ZERO_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rate_lock_o |-> (rate_code_o == '0)); // R8

endmodule

// File: tb/test_mcr_rate_detect.sv
module test_mcr_rate_detect;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [1:0] rate_code;
  logic       rate_lock;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // model state
  bit m_armed, m_havep, m_lock;
  int m_prev, m_code, pend;

  always #2.5 clk = ~clk;

  mcr_rate_detect i_mcr_rate_detect (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .frame_strobe_i (strobe),
    .rate_code_o    (rate_code),
    .rate_lock_o    (rate_lock)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  function automatic int lo_of(int k);
    return (k == 0) ? 190 : (256 << (k - 1)) - 2;
  endfunction

  function automatic int hi_of(int k);
    return (k == 0) ? 195 : (256 << (k - 1)) + 2;
  endfunction

  function automatic int classify(int n);
    for (int k = 0; k < 4; k++) if (n >= lo_of(k) && n <= hi_of(k)) return k;
    return -1;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_out(string tag);
    chk(tag, "lock", int'(rate_lock), int'(m_lock));
    chk(m_lock ? "R2" : "R8", "code", int'(rate_code), m_lock ? m_code : 0);
  endtask

  task automatic do_reset();
    strobe = 1'b0;
    rst_n  = 1'b0;
    m_armed = 0; m_havep = 0; m_lock = 0; m_prev = 0; m_code = 0; pend = 0;
    repeat (3) @(negedge clk);
    chk("R1", "lock in reset", int'(rate_lock), 0);
    chk("R1", "code in reset", int'(rate_code), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // One frame: strobe rises now, high for w cycles, next rise n cycles later.
  task automatic step(int n, int w);
    int meas, cls;
    string tag;
    strobe = 1'b1;
    if (!m_armed) begin
      m_armed = 1; tag = "R4";
    end else begin
      meas = (pend > 2047) ? 2047 : pend;
      cls  = classify(meas);
      if (cls < 0) begin
        m_lock = 0; m_havep = 0;
        tag = (meas == 2047) ? "R7" : "R5";
      end else if (m_havep && cls == m_prev) begin
        m_lock = 1; m_code = cls; tag = "R3";
      end else begin
        tag = m_havep ? "R6" : "R3";
        m_lock = 0; m_havep = 1; m_prev = cls;
      end
    end
    pend = n;
    @(negedge clk);
    check_out(tag);
    repeat (w - 1) @(negedge clk);
    strobe = 1'b0;
    repeat (n - w - 1) @(negedge clk);
    check_out("R10");
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();

    // R2: window edges of every class lock
    for (int k = 0; k < 4; k++) begin
      do_reset();
      step(lo_of(k), 1);
      step(hi_of(k), 1);
      step(lo_of(k), 1);
      chk("R2", "edge lock", int'(rate_lock), 1);
      chk("R2", "edge code", int'(rate_code), k);
    end

    // R2: one count beyond each edge never locks
    for (int k = 0; k < 4; k++) begin
      do_reset();
      step(lo_of(k) - 1, 1);
      step(lo_of(k) - 1, 1);
      step(hi_of(k) + 1, 1);
      step(hi_of(k) + 1, 1);
      chk("R2", "outside no lock", int'(rate_lock), 0);
    end

    // R4: two rises only give one measurement
    do_reset();
    step(256, 1);
    step(256, 1);
    chk("R4", "no lock after two rises", int'(rate_lock), 0);
    step(256, 1);
    chk("R4", "lock after third rise", int'(rate_lock), 1);

    // R5: mismatch drops lock, relocks after two good frames
    step(400, 1);
    step(256, 1);
    chk("R5", "dropped", int'(rate_lock), 0);
    step(256, 1);
    step(256, 1);
    chk("R5", "relocked", int'(rate_lock), 1);

    // R6: class change while locked
    step(512, 1);
    step(512, 1);
    chk("R6", "dropped on change", int'(rate_lock), 0);
    step(512, 1);
    chk("R6", "new class lock", int'(rate_lock), 1);
    chk("R6", "new class code", int'(rate_code), 2);

    // R7: stalled strobe saturates and clears lock
    step(2100, 1);
    step(1024, 1);
    chk("R7", "stall clears lock", int'(rate_lock), 0);
    step(1024, 1);
    step(1024, 1);
    chk("R7", "relock after stall", int'(rate_lock), 1);
    chk("R7", "relock code", int'(rate_code), 3);

    // R9: wide strobes count once per frame
    do_reset();
    step(192, 40);
    step(193, 40);
    step(192, 40);
    chk("R9", "wide strobe lock", int'(rate_lock), 1);
    chk("R9", "wide strobe code", int'(rate_code), 0);

    // random runs
    do_reset();
    for (int r = 0; r < 70; r++) begin
      int sel, k, run, n;
      sel = $urandom_range(0, 9);
      k   = $urandom_range(0, 3);
      run = $urandom_range(1, 4);
      for (int j = 0; j < run; j++) begin
        if (sel < 8) n = $urandom_range(lo_of(k), hi_of(k));
        else         n = $urandom_range(300, 480);
        step(n, $urandom_range(1, 4));
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule